// File: doc/BRIEF.md
# Page Translation Unit with Tagged Translation Buffer

This block turns a logical address from a processor into a physical address. The upper bits of the logical address form a page number and the lower bits form an offset within the page. A small fully associative translation buffer keeps recent page-to-frame mappings, and each mapping is tagged with an address-space ID. When a request finds a matching mapping, it completes one cycle after it is accepted and makes no memory access.

When no mapping matches, the unit reads one page-table entry from memory. The entry's word address is the table base register plus the page number. The unit writes the result into the buffer and then answers. The page-table length register bounds the lookup, so a page number outside the table faults at once. An entry whose valid bit is clear also faults and is never cached.

Two configuration registers set the table base and the table length. Writing either register, or pulsing the flush input, empties the buffer.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, req_ready is high, rsp_valid and mem_req are low, both table registers are zero (so every request faults), and the buffer holds no entries.
- R2: A successful translation returns rsp_paddr equal to the frame number joined above the unchanged OFS_W-bit page offset.
- R3: A request that matches a buffered entry gives rsp_valid in the cycle after it is accepted, with no memory read, and req_ready stays high, so matching requests can be accepted on consecutive cycles.
- R4: A request that matches no entry raises mem_req in the cycle after acceptance, with mem_addr = table base + page number. Both stay stable until mem_ack, and the response appears in the cycle after mem_ack.
- R5: A page number greater than or equal to the table length register produces a fault response in the next cycle without any memory read.
- R6: A table entry is PFN_W+1 bits wide, with the valid flag in the top bit and the frame number in the low PFN_W bits. An entry with a clear valid flag yields a fault and is not placed in the buffer, so a repeat request reads memory again.
- R7: req_ready is low from the cycle after a missing request is accepted until the cycle in which its response is presented.
- R8: A buffer hit requires both the page number and the address-space ID to match. The same page under another ID misses. At most one entry ever matches.
- R9: A one-cycle pulse on flush invalidates every buffer entry for all later requests.
- R10: A cfg_we cycle writes the base register when cfg_sel is 0 and writes the length register (cfg_wdata bits VPN_W down to 0) when cfg_sel is 1. Either write also invalidates every buffer entry.
- R11: The buffer has ENTRIES slots. Fills go to a round-robin pointer that advances by one per fill. After ENTRIES fills into an empty buffer, the next fill evicts the oldest one.
- R12: Every fault response carries rsp_paddr equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | VA_W | Logical address |
| req_asid | input | ASID_W | Address-space ID of the request |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_paddr | output | PA_W | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation failed |
| flush | input | 1 | Invalidate all buffer entries |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table length |
| cfg_wdata | input | PA_W | Configuration write data |
| mem_req | output | 1 | Table-entry read outstanding |
| mem_addr | output | PA_W | Word address of the table entry |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | PFN_W+1 | Table entry read from memory |

## Verification
Repeated requests to one page under one ID separate buffer hits from table reads: the second request must finish in a single cycle without a read. Requests that change only the address-space ID, or that follow a flush or a register write, must miss again, which shows that tagging and invalidation work. Page numbers just below and exactly at the table length, and pages whose entry is marked invalid, exercise both fault paths. A sweep of nine distinct pages checks round-robin eviction by showing that the oldest page misses while the second-oldest still hits. A behavioural model running beside the design compares every output on every cycle.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    typedef enum logic [0:0] {
        WALK_IDLE = 1'b0,
        WALK_WAIT = 1'b1
    } walk_state_e;

    localparam logic CFG_SEL_BASE = 1'b0;
    localparam logic CFG_SEL_LEN  = 1'b1;

endpackage

// File: rtl/pxu_cfg_regs.sv
module pxu_cfg_regs #(
    parameter int PA_W  = 16,
    parameter int VPN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [PA_W-1:0]  cfg_wdata,
    output logic [PA_W-1:0]  ptbase,
    output logic [VPN_W:0]   ptlen,
    output logic             cfg_flush
);
    typedef struct packed {
        logic [PA_W-1:0] base;
        logic [VPN_W:0]  len;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (cfg_sel == pxu_pkg::CFG_SEL_LEN) begin
                cfg_d.len = cfg_wdata[VPN_W:0];
            end else begin
                cfg_d.base = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ptbase    = cfg_q.base;
    assign ptlen     = cfg_q.len;
    assign cfg_flush = cfg_we;
endmodule

// File: rtl/pxu_tlb.sv
module pxu_tlb #(
    parameter int VPN_W   = 8,
    parameter int PFN_W   = 8,
    parameter int ASID_W  = 4,
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_hit,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic [ENTRIES-1:0] hit_vec,
    input  logic               ins_en,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [ASID_W-1:0]  ins_asid,
    input  logic [PFN_W-1:0]   ins_pfn,
    input  logic               flush_all
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic              vld;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
        logic  [IDX_W-1:0]   rr;
    } tlb_state_t;

    tlb_state_t tlb_d, tlb_q;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_masked;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign hit_vec[g] = tlb_q.slot[g].vld
                          && (tlb_q.slot[g].vpn  == lk_vpn)
                          && (tlb_q.slot[g].asid == lk_asid);
        assign pfn_masked[g] = {PFN_W{hit_vec[g]}} & tlb_q.slot[g].pfn;
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_pfn = lk_pfn | pfn_masked[i];
        end
    end

    assign lk_hit = |hit_vec;

    always_comb begin
        tlb_d = tlb_q;
        if (ins_en) begin
            tlb_d.slot[tlb_q.rr].vld  = 1'b1;
            tlb_d.slot[tlb_q.rr].asid = ins_asid;
            tlb_d.slot[tlb_q.rr].vpn  = ins_vpn;
            tlb_d.slot[tlb_q.rr].pfn  = ins_pfn;
            if (tlb_q.rr == LAST_IDX) begin
                tlb_d.rr = '0;
            end else begin
                tlb_d.rr = tlb_q.rr + IDX_W'(1);
            end
        end
        if (flush_all) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tlb_d.slot[i].vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tlb_q <= '0;
        end else begin
            tlb_q <= tlb_d;
        end
    end
endmodule

// File: rtl/pxu_walk_ctrl.sv
module pxu_walk_ctrl #(
    parameter int PA_W   = 16,
    parameter int OFS_W  = 8,
    parameter int VPN_W  = 8,
    parameter int ASID_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [PA_W-1:0]   ptbase,
    input  logic [VPN_W:0]    ptlen,
    input  logic              lk_hit,
    input  logic [PA_W-OFS_W-1:0] lk_pfn,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [PA_W-OFS_W:0] mem_rdata,
    output logic              ins_en,
    output logic [VPN_W-1:0]  ins_vpn,
    output logic [ASID_W-1:0] ins_asid,
    output logic [PA_W-OFS_W-1:0] ins_pfn
);
    import pxu_pkg::*;

    localparam int PFN_W = PA_W - OFS_W;
    localparam int PTE_W = PFN_W + 1;

    typedef struct packed {
        walk_state_e       state;
        logic [VPN_W-1:0]  vpn;
        logic [OFS_W-1:0]  ofs;
        logic [ASID_W-1:0] asid;
        logic [PA_W-1:0]   mem_addr;
        logic              rsp_valid;
        logic              rsp_fault;
        logic [PA_W-1:0]   rsp_paddr;
    } walk_state_t;

    walk_state_t w_d, w_q;
    logic out_of_range;

    assign out_of_range = ({1'b0, req_vpn} >= ptlen);

    always_comb begin
        w_d           = w_q;
        w_d.rsp_valid = 1'b0;
        w_d.rsp_fault = 1'b0;
        w_d.rsp_paddr = '0;
        ins_en        = 1'b0;
        unique case (w_q.state)
            WALK_IDLE: begin
                if (req_valid) begin
                    w_d.vpn  = req_vpn;
                    w_d.ofs  = req_ofs;
                    w_d.asid = req_asid;
                    if (out_of_range) begin
                        w_d.rsp_valid = 1'b1;
                        w_d.rsp_fault = 1'b1;
                    end else if (lk_hit) begin
                        w_d.rsp_valid = 1'b1;
                        w_d.rsp_paddr = {lk_pfn, req_ofs};
                    end else begin
                        w_d.state    = WALK_WAIT;
                        w_d.mem_addr = ptbase + PA_W'(req_vpn);
                    end
                end
            end
            WALK_WAIT: begin
                if (mem_ack) begin
                    w_d.state     = WALK_IDLE;
                    w_d.rsp_valid = 1'b1;
                    if (mem_rdata[PTE_W-1]) begin
                        w_d.rsp_paddr = {mem_rdata[PFN_W-1:0], w_q.ofs};
                        ins_en        = 1'b1;
                    end else begin
                        w_d.rsp_fault = 1'b1;
                    end
                end
            end
            default: w_d.state = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign req_ready = (w_q.state == WALK_IDLE);
    assign mem_req   = (w_q.state == WALK_WAIT);
    assign mem_addr  = w_q.mem_addr;
    assign rsp_valid = w_q.rsp_valid;
    assign rsp_fault = w_q.rsp_fault;
    assign rsp_paddr = w_q.rsp_paddr;
    assign ins_vpn   = w_q.vpn;
    assign ins_asid  = w_q.asid;
    assign ins_pfn   = mem_rdata[PFN_W-1:0];
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
    parameter int VA_W    = 16,
    parameter int PA_W    = 16,
    parameter int OFS_W   = 8,
    parameter int ASID_W  = 4,
    parameter int ENTRIES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [VA_W-1:0]         req_vaddr,
    input  logic [ASID_W-1:0]       req_asid,
    output logic                    rsp_valid,
    output logic [PA_W-1:0]         rsp_paddr,
    output logic                    rsp_fault,
    input  logic                    flush,
    input  logic                    cfg_we,
    input  logic                    cfg_sel,
    input  logic [PA_W-1:0]         cfg_wdata,
    output logic                    mem_req,
    output logic [PA_W-1:0]         mem_addr,
    input  logic                    mem_ack,
    input  logic [PA_W-OFS_W:0]     mem_rdata
);
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PFN_W = PA_W - OFS_W;

    logic [VPN_W-1:0]   req_vpn;
    logic [OFS_W-1:0]   req_ofs;
    logic [PA_W-1:0]    ptbase;
    logic [VPN_W:0]     ptlen;
    logic               cfg_flush;
    logic               flush_all;
    logic               lk_hit;
    logic [PFN_W-1:0]   lk_pfn;
    logic [ENTRIES-1:0] hit_vec;
    logic               ins_en;
    logic [VPN_W-1:0]   ins_vpn;
    logic [ASID_W-1:0]  ins_asid;
    logic [PFN_W-1:0]   ins_pfn;

    assign req_vpn   = req_vaddr[VA_W-1:OFS_W];
    assign req_ofs   = req_vaddr[OFS_W-1:0];
    assign flush_all = flush | cfg_flush;

    pxu_cfg_regs #(.PA_W(PA_W), .VPN_W(VPN_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ptbase(ptbase), .ptlen(ptlen), .cfg_flush(cfg_flush)
    );

    pxu_tlb #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .ENTRIES(ENTRIES)) u_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(req_vpn), .lk_asid(req_asid),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .hit_vec(hit_vec),
        .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_asid(ins_asid), .ins_pfn(ins_pfn),
        .flush_all(flush_all)
    );

    pxu_walk_ctrl #(.PA_W(PA_W), .OFS_W(OFS_W), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_ofs(req_ofs), .req_asid(req_asid),
        .ptbase(ptbase), .ptlen(ptlen),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_asid(ins_asid), .ins_pfn(ins_pfn)
    );
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
    parameter int PA_W    = 16,
    parameter int VPN_W   = 8,
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VPN_W-1:0]   req_vpn,
    input logic [VPN_W:0]     ptlen,
    input logic               rsp_valid,
    input logic               rsp_fault,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               mem_req,
    input logic [PA_W-1:0]    mem_addr,
    input logic               mem_ack,
    input logic               pte_valid,
    input logic [ENTRIES-1:0] hit_vec
);
    assert_wait_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_rsp_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_req && mem_ack)));

    assert_fault_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));

    assert_len_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_vpn} >= ptlen)) |=> (rsp_fault && !mem_req));

    assert_invalid_pte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !pte_valid) |=> rsp_fault);

    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

bind page_xlate_unit pxu_checker #(
    .PA_W(PA_W), .VPN_W(VA_W - OFS_W), .ENTRIES(ENTRIES)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .ptlen(ptlen),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .pte_valid(mem_rdata[PA_W-OFS_W]), .hit_vec(hit_vec)
);

// File: tb/sim_page_xlate_unit.sv
module sim_page_xlate_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_vaddr = '0;
    logic [3:0]  req_asid = '0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic        rsp_fault;
    logic        flush = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [8:0]  mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlate_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_asid(req_asid),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .flush(flush), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int total = 0, bad = 0, cyc = 0, reads = 0, mcnt = 0;
    bit timed_out = 0;
    // reference model state
    int tv[8], tvpn[8], tasid[8], tpfn[8];
    int rr = 0, m_base = 0, m_len = 0, m_vpn = 0, m_ofs = 0, m_addr = 0;
    bit m_busy = 0, accepted = 0;
    bit e_ready = 1, e_mreq = 0, e_rv = 0, e_rf = 0;
    int e_pa = 0, e_maddr = 0;
    bit got_rsp = 0, got_fault = 0;
    int got_pa = 0;

    function automatic logic [8:0] pte_of(int a);
        logic [7:0] f;
        f = 8'((a * 7 + 3) & 255);
        return {((a % 5) != 4), f};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 8; i++) tv[i] = 0;
    endtask

    task automatic model_step();
        int vpn, hit;
        accepted = 0; e_rv = 0; e_rf = 0; e_pa = 0;
        if (!m_busy) begin
            if (req_valid) begin
                accepted = 1;
                vpn = int'(req_vaddr) >> 8;
                if (vpn >= m_len) begin
                    e_rv = 1; e_rf = 1;
                end else begin
                    hit = -1;
                    for (int i = 0; i < 8; i++)
                        if (tv[i] != 0 && tvpn[i] == vpn && tasid[i] == int'(req_asid)) hit = i;
                    if (hit >= 0) begin
                        e_rv = 1; e_pa = (tpfn[hit] << 8) | (int'(req_vaddr) & 255);
                    end else begin
                        m_busy = 1; m_vpn = vpn; m_ofs = int'(req_vaddr) & 255;
                        tasid_pending = int'(req_asid);
                        m_addr = (m_base + vpn) & 16'hFFFF;
                    end
                end
            end
        end else if (mem_ack) begin
            m_busy = 0; e_rv = 1;
            if (mem_rdata[8]) begin
                e_pa = (int'(mem_rdata[7:0]) << 8) | m_ofs;
                tv[rr] = 1; tvpn[rr] = m_vpn; tasid[rr] = tasid_pending; tpfn[rr] = int'(mem_rdata[7:0]);
                rr = (rr + 1) % 8;
            end else begin
                e_rf = 1;
            end
        end
        if (cfg_we) begin
            if (cfg_sel) m_len = int'(cfg_wdata) & 16'h1FF;
            else m_base = int'(cfg_wdata);
            clear_all();
        end
        if (flush) clear_all();
        e_ready = !m_busy; e_mreq = m_busy; e_maddr = m_addr;
    endtask

    int tasid_pending = 0;

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        chk(req_ready == e_ready, "R7 req_ready", int'(req_ready), int'(e_ready));
        chk(mem_req == e_mreq, "R4 mem_req", int'(mem_req), int'(e_mreq));
        if (e_mreq) chk(int'(mem_addr) == e_maddr, "R4 mem_addr", int'(mem_addr), e_maddr);
        chk(rsp_valid == e_rv, "R3 rsp_valid", int'(rsp_valid), int'(e_rv));
        if (e_rv) begin
            chk(rsp_fault == e_rf, "R5/R6 rsp_fault", int'(rsp_fault), int'(e_rf));
            chk(int'(rsp_paddr) == e_pa, "R2 rsp_paddr", int'(rsp_paddr), e_pa);
        end
        if (rsp_valid) begin
            got_rsp = 1; got_fault = rsp_fault; got_pa = int'(rsp_paddr);
        end
        mem_ack = 1'b0;
        if (mem_req) begin
            mcnt++;
            if (mcnt >= LAT) begin
                mem_ack = 1'b1; mem_rdata = pte_of(int'(mem_addr)); mcnt = 0; reads++;
            end
        end
        if (cyc > WD_LIMIT && !timed_out) begin
            timed_out = 1; total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
        end
    endtask

    task automatic issue(int va, int as);
        req_vaddr = 16'(va); req_asid = 4'(as); req_valid = 1'b1; got_rsp = 0;
        while (req_valid && !timed_out) begin
            tick();
            if (accepted) req_valid = 1'b0;
        end
        while (!got_rsp && !timed_out) tick();
    endtask

    task automatic cfg_write(bit sel, int val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 16'(val);
        tick();
        cfg_we = 1'b0;
    endtask

    initial begin
        int r0, pa_exp, nfound;
        int pg[9];
        logic [8:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", int'(mem_req), 0);
        @(negedge clk);
        r0 = reads;
        issue(16'h0123, 1);
        chk(got_fault == 1'b1, "R1 zero length faults", int'(got_fault), 1);
        chk(got_pa == 0, "R12 fault paddr", got_pa, 0);
        chk(reads == r0, "R5 no read on range fault", reads, r0);

        cfg_write(1'b0, 16'h0100);
        cfg_write(1'b1, 16'h0040);

        // miss then hit (R2, R3, R4)
        r0 = reads;
        issue(16'h0512, 1);
        p = pte_of(16'h105); pa_exp = (int'(p[7:0]) << 8) | 16'h12;
        chk(got_pa == pa_exp, "R2 miss paddr", got_pa, pa_exp);
        chk(reads == r0 + 1, "R4 one table read", reads, r0 + 1);
        r0 = reads;
        issue(16'h05AB, 1);
        pa_exp = (int'(p[7:0]) << 8) | 16'hAB;
        chk(got_pa == pa_exp, "R2 hit paddr", got_pa, pa_exp);
        chk(reads == r0, "R3 hit without read", reads, r0);

        // R8: other address space misses
        issue(16'h0501, 2);
        chk(reads == r0 + 1, "R8 asid mismatch misses", reads, r0 + 1);

        // R3: back-to-back hits on consecutive cycles
        r0 = reads;
        req_valid = 1'b1; req_vaddr = 16'h0577; req_asid = 4'd1;
        tick();
        req_vaddr = 16'h0588; req_asid = 4'd2;
        tick();
        req_valid = 1'b0;
        chk(reads == r0, "R3 burst of hits no read", reads, r0);

        // R6: invalid entry faults and is not cached (base 0x100 + 3 = invalid)
        r0 = reads;
        issue(16'h0300, 1);
        chk(got_fault == 1'b1, "R6 invalid entry faults", int'(got_fault), 1);
        issue(16'h0300, 1);
        chk(reads == r0 + 2, "R6 invalid not installed", reads, r0 + 2);
        chk(got_pa == 0, "R12 invalid fault paddr", got_pa, 0);

        // R5: boundary of table length
        r0 = reads;
        issue(16'h4000, 1);
        chk(got_fault == 1'b1 && reads == r0, "R5 vpn equal to length", reads, r0);
        issue(16'h3F00, 1);
        chk(reads == r0 + 1, "R5 last legal page reads", reads, r0 + 1);

        // R9: flush
        pulse_flush();
        r0 = reads;
        issue(16'h0512, 1);
        chk(reads == r0 + 1, "R9 flush forces miss", reads, r0 + 1);

        // R10: register writes flush and retarget
        cfg_write(1'b1, 16'h0040);
        r0 = reads;
        issue(16'h0512, 1);
        chk(reads == r0 + 1, "R10 length write flushes", reads, r0 + 1);
        cfg_write(1'b0, 16'h0200);
        issue(16'h0534, 1);
        p = pte_of(16'h205); pa_exp = (int'(p[7:0]) << 8) | 16'h34;
        chk(got_pa == pa_exp, "R10 new base used", got_pa, pa_exp);

        // R11: round-robin eviction
        nfound = 0;
        for (int v = 16'h20; v < 16'h3F && nfound < 9; v++) begin
            p = pte_of(16'h200 + v);
            if (p[8]) begin pg[nfound] = v; nfound++; end
        end
        pulse_flush();
        for (int i = 0; i < 9; i++) issue(pg[i] << 8, 3);
        r0 = reads;
        issue((pg[1] << 8) | 5, 3);
        chk(reads == r0, "R11 second-oldest still held", reads, r0);
        issue((pg[0] << 8) | 5, 3);
        chk(reads == r0 + 1, "R11 oldest evicted", reads, r0 + 1);

        repeat (3) tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic pulse_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            tv[i] = 0; tvpn[i] = 0; tasid[i] = 0; tpfn[i] = 0;
        end
    end
endmodule